// File: doc/BRIEF.md
# Sprite Page Copy Engine

This block moves one whole 256-byte page of processor address space into a single fixed destination register. The processor stays stalled for the whole move. A write of a page number to the trigger address starts a transfer. The engine then takes over the bus. For each byte it spends one cycle reading the source and one cycle writing the destination. Bytes are copied from offset 0x00 up to 0xFF.

Before the first read the engine inserts one or two idle alignment cycles. It chooses one or two from the cycle parity input, sampled together with the trigger write: an odd cycle gives one idle cycle and an even cycle gives two. The stall therefore lasts 513 or 514 cycles. In the cycle after the last write the engine releases the stall and raises a one-cycle done pulse.

The controller has five named states:
- `DS_IDLE`: waiting for a trigger.
- `DS_PAD_A`: the extra alignment cycle, used only after an even-cycle start.
- `DS_PAD_B`: the alignment cycle that every transfer has.
- `DS_FETCH`: source read.
- `DS_STORE`: destination write.

The transitions are:
- IDLE→PAD_B when the trigger arrives on an odd cycle.
- IDLE→PAD_A when the trigger arrives on an even cycle.
- PAD_A→PAD_B.
- PAD_B→FETCH.
- FETCH→STORE.
- STORE→FETCH while bytes remain.
- STORE→IDLE after offset 0xFF.

Top module: `spr_page_dma`

## Requirements
- R1: While reset is active, and in the first idle cycle after it, `cpu_halt`, `done` and `bus_we` are low and `bus_addr` is zero. A reset asserted mid-transfer drops `cpu_halt` immediately.
- R2: A transfer starts only when `cpu_wr_en` is high and `cpu_addr` equals the trigger address (default 0x4014) while the engine is idle. A write to any other address, or the trigger address presented with `cpu_wr_en` low, leaves `cpu_halt` low.
- R3: Source reads present `bus_addr = {page, offset}`, with the page taken from `cpu_wdata` at the trigger. Offsets rise from 0x00 to 0xFF. Each read cycle is followed immediately by exactly one write cycle.
- R4: Every write cycle drives `bus_we` high, `bus_addr` equal to the destination address (default 0x2004), and `bus_wdata` equal to the `bus_rdata` seen in the preceding read cycle.
- R5: The transfer contains one alignment cycle if `cycle_odd` was 1 at the trigger, for 513 stalled cycles in total. It contains two alignment cycles if `cycle_odd` was 0, for 514 in total.
- R6: Alignment cycles drive `bus_we` low and `bus_addr` zero.
- R7: `cpu_halt` is high in every cycle from the first alignment cycle through the final write, and in no other cycle.
- R8: `done` is high for exactly the one cycle after the final write, and `cpu_halt` is low in that cycle.
- R9: A trigger write during an active transfer is ignored. The source page, the transfer length and the idle state afterwards are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_en | input | 1 | Processor write strobe |
| cpu_addr | input | 16 | Processor write address |
| cpu_wdata | input | 8 | Processor write data (page number at the trigger) |
| cycle_odd | input | 1 | High on odd processor cycles |
| bus_addr | output | 16 | Address driven while the engine owns the bus |
| bus_rdata | input | 8 | Data returned for the current read address |
| bus_wdata | output | 8 | Data driven in write cycles |
| bus_we | output | 1 | Write enable |
| cpu_halt | output | 1 | Processor stall |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong state in the controller shows up at the ports within one cycle:
- A skipped or extra alignment state changes the stall length from 513/514.
- A dropped FETCH or STORE state breaks the strict read/write alternation on `bus_we`.

A wrong offset or page register shows up at the next write cycle. There, the address read in the preceding cycle and the echoed data no longer match `{page, offset}` and the memory contents. A page register that reloads mid-transfer exposes itself in the first read after the stray trigger. A late or early done flag is visible in the cycle the stall drops.

// File: rtl/spr_dma_pkg.sv
package spr_dma_pkg;

    // Controller states; PAD_A exists only on even-cycle starts.
    typedef enum logic [2:0] {
        DS_IDLE,
        DS_PAD_A,
        DS_PAD_B,
        DS_FETCH,
        DS_STORE
    } dma_state_e;

endpackage

// File: rtl/spr_dma_fsm.sv
module spr_dma_fsm
    import spr_dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       start_odd,
    input  logic       last_byte,
    output dma_state_e state_o,
    output logic       load_page,
    output logic       advance,
    output logic       halt,
    output logic       wr_en,
    output logic       done
);

    dma_state_e state_q;
    dma_state_e state_d;
    logic       done_q;

    // State register and registered completion flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DS_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == DS_STORE) && last_byte;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DS_IDLE: begin
                if (start_req) begin
                    state_d = start_odd ? DS_PAD_B : DS_PAD_A;
                end
            end
            DS_PAD_A: state_d = DS_PAD_B;
            DS_PAD_B: state_d = DS_FETCH;
            DS_FETCH: state_d = DS_STORE;
            DS_STORE: state_d = last_byte ? DS_IDLE : DS_FETCH;
            default:  state_d = DS_IDLE;
        endcase
    end

    // Output decode.
    always_comb begin
        load_page = 1'b0;
        advance   = 1'b0;
        halt      = 1'b1;
        wr_en     = 1'b0;
        unique case (state_q)
            DS_IDLE: begin
                halt      = 1'b0;
                load_page = start_req;
            end
            DS_PAD_A, DS_PAD_B, DS_FETCH: begin
                halt = 1'b1;
            end
            DS_STORE: begin
                wr_en   = 1'b1;
                advance = 1'b1;
            end
            default: halt = 1'b0;
        endcase
    end

    assign state_o = state_q;
    assign done    = done_q;

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R5
    odd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DS_IDLE && start_req && start_odd) |=> (state_q == DS_PAD_B));

    // R5
    even_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DS_IDLE && start_req && !start_odd) |=> (state_q == DS_PAD_A));

endmodule

// File: rtl/spr_dma_addr.sv
module spr_dma_addr
    import spr_dma_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                OFS_W     = 8,
    parameter int                PAGE_W    = ADDR_W - OFS_W,
    parameter logic [ADDR_W-1:0] DEST_ADDR = 16'h2004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dma_state_e        state,
    input  logic              load_page,
    input  logic              advance,
    input  logic [PAGE_W-1:0] page_in,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              last_byte
);

    localparam logic [OFS_W-1:0] OFS_LAST = '1;

    logic [PAGE_W-1:0] page_q;
    logic [OFS_W-1:0]  ofs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
            ofs_q  <= '0;
        end else if (load_page) begin
            page_q <= page_in;
            ofs_q  <= '0;
        end else if (advance) begin
            ofs_q <= ofs_q + 1'b1;
        end
    end

    assign last_byte = (ofs_q == OFS_LAST);

    always_comb begin
        unique case (state)
            DS_FETCH: bus_addr = {page_q, ofs_q};
            DS_STORE: bus_addr = DEST_ADDR;
            default:  bus_addr = '0;
        endcase
    end

    // R9
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != DS_IDLE) && $past(state != DS_IDLE) |-> $stable(page_q));

    // R3
    fetch_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DS_FETCH) && $past(state == DS_STORE) |-> (ofs_q != '0));

endmodule

// File: rtl/spr_dma_latch.sv
module spr_dma_latch
    import spr_dma_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dma_state_e        state,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] wdata
);

    logic [DATA_W-1:0] byte_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q <= '0;
        end else if (state == DS_FETCH) begin
            byte_q <= rdata;
        end
    end

    assign wdata = (state == DS_STORE) ? byte_q : '0;

endmodule

// File: rtl/spr_page_dma.sv
module spr_page_dma
    import spr_dma_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 8,
    parameter int                OFS_W     = 8,
    parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014,
    parameter logic [ADDR_W-1:0] DEST_ADDR = 16'h2004
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr_en,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cycle_odd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              cpu_halt,
    output logic              done
);

    localparam int PAGE_W = ADDR_W - OFS_W;

    dma_state_e        state;
    logic              start_req;
    logic              load_page;
    logic              advance;
    logic              last_byte;
    logic [PAGE_W-1:0] page_in;

    assign start_req = cpu_wr_en && (cpu_addr == TRIG_ADDR);

    // Page number extraction adapts to the data/page width relation.
    generate
        if (DATA_W >= PAGE_W) begin : g_page_slice
            assign page_in = cpu_wdata[PAGE_W-1:0];
        end else begin : g_page_pad
            assign page_in = {{(PAGE_W-DATA_W){1'b0}}, cpu_wdata};
        end
    endgenerate

    spr_dma_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .start_odd (cycle_odd),
        .last_byte (last_byte),
        .state_o   (state),
        .load_page (load_page),
        .advance   (advance),
        .halt      (cpu_halt),
        .wr_en     (bus_we),
        .done      (done)
    );

    spr_dma_addr #(
        .ADDR_W    (ADDR_W),
        .OFS_W     (OFS_W),
        .PAGE_W    (PAGE_W),
        .DEST_ADDR (DEST_ADDR)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .load_page (load_page),
        .advance   (advance),
        .page_in   (page_in),
        .bus_addr  (bus_addr),
        .last_byte (last_byte)
    );

    spr_dma_latch #(
        .DATA_W (DATA_W)
    ) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .state (state),
        .rdata (bus_rdata),
        .wdata (bus_wdata)
    );

    // R4
    dest_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> (bus_addr == DEST_ADDR));

    // R4
    wdata_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> (bus_wdata == $past(bus_rdata)));

    // R3
    read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> ($past(cpu_halt) && !$past(bus_we)));

    // R7
    halt_covers_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> cpu_halt);

    // R8
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!cpu_halt && $past(bus_we)));

endmodule

// File: tb/test_spr_page_dma.sv
module test_spr_page_dma;

    localparam int          CLK_PERIOD = 10;
    localparam int          WATCHDOG   = 20000;
    localparam logic [15:0] TRIG       = 16'h4014;
    localparam logic [15:0] DEST       = 16'h2004;

    typedef struct packed {
        logic [7:0]  page;
        logic        odd;
        logic [15:0] poke;   // stall cycle at which a stray trigger is written, 0 = none
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{page: 8'h00, odd: 1'b1, poke: 16'd0},
        '{page: 8'h02, odd: 1'b0, poke: 16'd0},
        '{page: 8'hFF, odd: 1'b1, poke: 16'd0},
        '{page: 8'h80, odd: 1'b0, poke: 16'd100},
        '{page: 8'h41, odd: 1'b1, poke: 16'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr_en = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cycle_odd = 1'b0;
    logic [15:0] bus_addr;
    logic [7:0]  bus_rdata;
    logic [7:0]  bus_wdata;
    logic        bus_we;
    logic        cpu_halt;
    logic        done;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mem_f(input logic [15:0] a);
        return a[7:0] ^ {a[14:8], a[15]} ^ 8'h3C;
    endfunction

    assign bus_rdata = mem_f(bus_addr);

    spr_page_dma i_spr_page_dma (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_wr_en (cpu_wr_en),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cycle_odd (cycle_odd),
        .bus_addr  (bus_addr),
        .bus_rdata (bus_rdata),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .cpu_halt  (cpu_halt),
        .done      (done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // One full transfer with per-cycle port checks.
    task automatic run_xfer(input logic [7:0] pg, input logic odd, input int poke_at);
        int n = 0;
        int w = 0;
        int exp_len = odd ? 513 : 514;
        int pads = exp_len - 512;
        logic [15:0] prev_addr = '0;
        logic        prev_we = 1'b0;
        bit ok_pad = 1'b1;
        bit ok_alt = 1'b1;
        @(negedge clk);
        cpu_wr_en = 1'b1; cpu_addr = TRIG; cpu_wdata = pg; cycle_odd = odd;
        @(negedge clk);
        cpu_wr_en = 1'b0; cycle_odd = ~odd;
        while (cpu_halt === 1'b1 && n < 600) begin
            n++;
            if (n <= pads) begin
                // R6 alignment cycles are silent
                if (bus_we !== 1'b0 || bus_addr !== 16'h0000) begin
                    ok_pad = 1'b0;
                    chk(1'b0, "R6 pad cycle", {15'd0, bus_we, bus_addr}, 32'h0);
                end
            end
            if (bus_we === 1'b1) begin
                chk(bus_addr == DEST, "R4 dest address", bus_addr, DEST);
                chk(prev_addr == {pg, w[7:0]}, "R3 source address", prev_addr, {pg, w[7:0]});
                chk(bus_wdata == mem_f({pg, w[7:0]}), "R4 write data", bus_wdata, mem_f({pg, w[7:0]}));
                if (prev_we) ok_alt = 1'b0;
                w++;
            end else if (n > pads && prev_we == 1'b0 && n != pads + 1) begin
                ok_alt = 1'b0;
            end
            prev_addr = bus_addr;
            prev_we   = bus_we;
            if (poke_at != 0 && n == poke_at) begin
                cpu_wr_en = 1'b1; cpu_addr = TRIG; cpu_wdata = pg ^ 8'h55; cycle_odd = ~odd;
            end else begin
                cpu_wr_en = 1'b0;
            end
            @(negedge clk);
        end
        cpu_wr_en = 1'b0;
        chk(n == exp_len, "R5/R7 stall length", n, exp_len);
        chk(w == 256, "R3 byte count", w, 256);
        chk(ok_alt, "R3 read/write alternation", ok_alt, 1);
        chk(ok_pad, "R6 pad cycles", ok_pad, 1);
        chk(done === 1'b1, "R8 done after final write", done, 1);
        chk(bus_we === 1'b0, "R8 no write in done cycle", bus_we, 0);
        @(negedge clk);
        chk(done === 1'b0, "R8 done single cycle", done, 0);
        // R9 a stray trigger must not leave a pending restart
        chk(cpu_halt === 1'b0, "R9 idle after transfer", cpu_halt, 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // R1 reset state
        #(CLK_PERIOD*2 + 1);
        chk(cpu_halt === 1'b0 && done === 1'b0 && bus_we === 1'b0, "R1 outputs in reset",
            {cpu_halt, done, bus_we}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_addr === 16'h0 && cpu_halt === 1'b0, "R1 idle after reset", {cpu_halt, bus_addr}, 0);

        // R2 non-trigger writes
        cpu_wr_en = 1'b1; cpu_addr = 16'h4015; cpu_wdata = 8'h12;
        @(negedge clk);
        cpu_wr_en = 1'b0;
        chk(cpu_halt === 1'b0, "R2 other address ignored", cpu_halt, 0);
        cpu_addr = TRIG;
        @(negedge clk);
        chk(cpu_halt === 1'b0, "R2 strobe low ignored", cpu_halt, 0);

        // Table-driven transfers: R3 R4 R5 R6 R7 R8 R9
        for (int i = 0; i < 5; i++) begin
            run_xfer(VEC[i].page, VEC[i].odd, int'(VEC[i].poke));
        end

        // R1 reset in the middle of a transfer
        @(negedge clk);
        cpu_wr_en = 1'b1; cpu_addr = TRIG; cpu_wdata = 8'h10; cycle_odd = 1'b0;
        @(negedge clk);
        cpu_wr_en = 1'b0;
        repeat (40) @(negedge clk);
        chk(cpu_halt === 1'b1, "R7 halt mid transfer", cpu_halt, 1);
        rst_n = 1'b0;
        #1;
        chk(cpu_halt === 1'b0 && bus_we === 1'b0, "R1 reset aborts", {cpu_halt, bus_we}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cpu_halt === 1'b0 && done === 1'b0, "R1 quiet after abort", {cpu_halt, done}, 0);

        // A fresh transfer after the abort
        run_xfer(8'h7E, 1'b0, 0);

        summary();
        $finish;
    end

endmodule